// File: doc/BRIEF.md
# Two-Channel Time-Slot Serial Port

This block connects one 8-bit voice channel to a bit-serial link that carries two B channels per frame, as in a 2B+D interchip link. It runs directly on the link's bit clock. A sync pulse, one bit clock wide, marks the start of a frame. The block counts bit-clock edges from that pulse to find the first B slot (B1) or the second B slot (B2). A select input chooses which of the two slots the port uses, and the same slot is used for both directions.

On transmit, the block sends a parallel byte most significant bit first. Each bit is launched on a rising edge of the bit clock. Outside the selected slot, the data line is released. High impedance is modelled by a separate active-high output enable next to the data bit, so the design needs no internal tristate. On receive, the block samples the serial input on falling edges, MSB first. When the eighth bit has been sampled, it presents the assembled byte with a one-cycle valid strobe. A sync pulse that arrives in the middle of a frame restarts the count, and any byte that has been only partly received is dropped.

Top module: `ts_port`

## Requirements
- R1: While `rst` is high and after it is released, `tx_oe` is 0, `rx_valid` is 0 and `rx_byte` is 0 until the first sync pulse is seen.
- R2: With `slot_sel`=0 captured at the sync edge, the captured transmit byte appears on `tx_bit` MSB first. Each bit is launched on one of the rising edges 1 through 8 that follow the rising edge where `sync_in` is sampled high, and `tx_oe` is 1 for exactly those 8 cycles.
- R3: With `slot_sel`=1 captured at the sync edge, the same holds on rising edges 11 through 18.
- R4: Outside the selected slot, including the other channel's slot and the sync cycle itself, `tx_oe` is 0 and `tx_bit` is 0.
- R5: `tx_byte` and `slot_sel` are captured only at the sync edge. Changes to them later in the frame have no effect until the next sync pulse.
- R6: With slot 0 selected, `rx_bit` is sampled on falling edges 1 through 8 after the sync edge. The first sample becomes bit 7 of `rx_byte`.
- R7: With slot 1 selected, `rx_bit` is sampled on falling edges 11 through 18, MSB first.
- R8: `rx_valid` is high for exactly one cycle. It rises at the rising edge right after the last falling-edge sample of the slot (edge 9 for B1, edge 19 for B2). `rx_byte` then holds that value until the next completed slot.
- R9: A sync pulse seen before a slot has completed restarts the frame. No `rx_valid` is raised for the interrupted byte, and `rx_byte` is unchanged.
- R10: Without any sync pulse, the port stays idle: `tx_oe` is 0 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; transmit launches on the rising edge, receive samples on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame sync, one bit clock wide |
| slot_sel | input | 1 | Slot choice: 0 = first B slot, 1 = second B slot |
| tx_byte | input | 8 | Byte to send, captured at the sync edge |
| rx_bit | input | 1 | Serial receive data |
| tx_bit | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit drive enable; 0 means the line floats |
| rx_byte | output | 8 | Last fully received byte |
| rx_valid | output | 1 | One-cycle strobe when a new `rx_byte` is presented |

## Verification
A wrong edge count or a stale slot selection shows up within one bit clock of the expected slot start. `tx_oe` rises a cycle early or late, or in the wrong slot, and the bench sees the mismatch on the first cycle that differs. A fault in the receive shift path or the sample index shows at `rx_byte` on the strobe cycle at the end of the slot. Non-slot data on `rx_bit` is driven with alternating values, so an off-by-one sample corrupts the byte. A restart fault, or a strobe that is missing or doubled, shows at `rx_valid` within a frame of about twenty cycles.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam int SLOT_BITS = 8;
    localparam int B1_FIRST  = 1;
    localparam int B2_FIRST  = 11;
    localparam int LAST_EDGE = B2_FIRST + SLOT_BITS - 1;
    localparam int IDLE_EDGE = LAST_EDGE + 2;
    localparam int EDGE_W    = $clog2(IDLE_EDGE + 1);

    typedef logic [EDGE_W-1:0]    edge_t;
    typedef logic [SLOT_BITS-1:0] octet_t;

    typedef enum logic {
        SLOT_B1 = 1'b0,
        SLOT_B2 = 1'b1
    } slot_e;

    typedef struct packed {
        edge_t idx;
        slot_e slot;
    } frame_t;

    function automatic edge_t first_edge(slot_e s);
        return (s == SLOT_B2) ? edge_t'(B2_FIRST) : edge_t'(B1_FIRST);
    endfunction

    function automatic logic in_slot(edge_t e, slot_e s);
        return (e >= first_edge(s)) && (e <= first_edge(s) + edge_t'(SLOT_BITS - 1));
    endfunction

    function automatic logic slot_end(edge_t e, slot_e s);
        return e == first_edge(s) + edge_t'(SLOT_BITS - 1);
    endfunction
endpackage

// File: rtl/ts_frame_timer.sv
module ts_frame_timer
    import ts_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_in,
    input  logic   slot_sel,
    output frame_t frame
);
    frame_t fr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q.idx  <= edge_t'(IDLE_EDGE);
            fr_q.slot <= SLOT_B1;
        end else if (sync_in) begin
            fr_q.idx  <= edge_t'(1);
            fr_q.slot <= slot_e'(slot_sel);
        end else if (fr_q.idx != edge_t'(IDLE_EDGE)) begin
            fr_q.idx  <= fr_q.idx + edge_t'(1);
        end
    end

    assign frame = fr_q;
endmodule

// File: rtl/ts_tx_slot.sv
module ts_tx_slot
    import ts_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_in,
    input  frame_t frame,
    input  octet_t tx_byte,
    output logic   tx_bit,
    output logic   tx_oe
);
    octet_t sh_q;
    logic   bit_q;
    logic   oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (sync_in) begin
            sh_q  <= tx_byte;
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (in_slot(frame.idx, frame.slot)) begin
            bit_q <= sh_q[SLOT_BITS-1];
            sh_q  <= {sh_q[SLOT_BITS-2:0], 1'b0};
            oe_q  <= 1'b1;
        end else begin
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end
    end

    assign tx_bit = bit_q;
    assign tx_oe  = oe_q;

    // R4
    oe_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> !tx_oe);

    // R4
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> !tx_bit);

    // R2 R3
    oe_start_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_oe) |-> ($past(frame.idx) == edge_t'(B1_FIRST)) ||
                         ($past(frame.idx) == edge_t'(B2_FIRST)));
endmodule

// File: rtl/ts_rx_slot.sv
module ts_rx_slot
    import ts_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  frame_t frame,
    input  logic   rx_bit,
    output octet_t rx_byte,
    output logic   rx_valid
);
    octet_t sh_n;
    logic   done_n;
    octet_t byte_q;
    logic   vld_q;
    edge_t  fall_idx;

    assign fall_idx = frame.idx - edge_t'(1);

    always_ff @(negedge clk) begin
        if (rst) begin
            sh_n   <= '0;
            done_n <= 1'b0;
        end else begin
            done_n <= 1'b0;
            if (in_slot(fall_idx, frame.slot)) begin
                sh_n <= {sh_n[SLOT_BITS-2:0], rx_bit};
                if (slot_end(fall_idx, frame.slot)) begin
                    done_n <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= done_n;
            if (done_n) begin
                byte_q <= sh_n;
            end
        end
    end

    assign rx_byte  = byte_q;
    assign rx_valid = vld_q;

    // R8
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_byte));
endmodule

// File: rtl/ts_port.sv
module ts_port
    import ts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_in,
    input  logic       slot_sel,
    input  logic [7:0] tx_byte,
    input  logic       rx_bit,
    output logic       tx_bit,
    output logic       tx_oe,
    output logic [7:0] rx_byte,
    output logic       rx_valid
);
    frame_t frame;

    ts_frame_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .slot_sel(slot_sel),
        .frame   (frame)
    );

    ts_tx_slot u_tx (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .frame   (frame),
        .tx_byte (tx_byte),
        .tx_bit  (tx_bit),
        .tx_oe   (tx_oe)
    );

    ts_rx_slot u_rx (
        .clk     (clk),
        .rst     (rst),
        .frame   (frame),
        .rx_bit  (rx_bit),
        .rx_byte (rx_byte),
        .rx_valid(rx_valid)
    );
endmodule

// File: tb/sim_ts_port.sv
module sim_ts_port;
    logic       clk = 1'b0;
    logic       rst;
    logic       sync_in;
    logic       slot_sel;
    logic [7:0] tx_byte;
    logic       rx_bit;
    logic       tx_bit;
    logic       tx_oe;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;
    logic [7:0] held = 8'h00;

    typedef struct {
        logic       oe;
        logic       bt;
        logic       vld;
        logic [7:0] byt;
        string      ttag;
        string      rtag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    ts_port u0 (
        .clk(clk), .rst(rst), .sync_in(sync_in), .slot_sel(slot_sel),
        .tx_byte(tx_byte), .rx_bit(rx_bit), .tx_bit(tx_bit), .tx_oe(tx_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always begin
        @(posedge clk);
        #5;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.ttag, "tx_oe", int'(tx_oe), int'(e.oe));
            chk(e.ttag, "tx_bit", int'(tx_bit), int'(e.bt));
            chk(e.rtag, "rx_valid", int'(rx_valid), int'(e.vld));
            chk(e.rtag, "rx_byte", int'(rx_byte), int'(e.byt));
        end
    end

    // R10: idle cycles without sync
    task automatic idle(input int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            exp_t e;
            @(posedge clk);
            #2;
            rx_bit = n[0];
            e.oe = 1'b0; e.bt = 1'b0; e.vld = 1'b0; e.byt = held;
            e.ttag = "R10"; e.rtag = "R10";
            q.push_back(e);
        end
    endtask

    // Drives one frame: sync now (sampled at next rising edge), then ncyc cycles.
    task automatic frame(input logic sel, input logic [7:0] txb, input logic [7:0] rxb,
                         input int ncyc, input logic cut);
        int first;
        first = sel ? 11 : 1;
        sync_in  = 1'b1;
        slot_sel = sel;
        tx_byte  = txb;
        for (int n = 0; n < ncyc; n++) begin
            exp_t e;
            logic ins;
            @(posedge clk);
            #2;
            if (n == 0) begin
                sync_in  = 1'b0;
                tx_byte  = ~txb;   // R5: late change must be ignored
                slot_sel = ~sel;   // R5
            end
            ins  = (n >= first) && (n < first + 8);
            e.oe = ins;
            e.bt = ins ? txb[7 - (n - first)] : 1'b0;
            e.vld = (n == first + 8);
            if (e.vld) held = rxb;
            e.byt = held;
            e.ttag = ins ? (sel ? "R3 R5" : "R2 R5") : "R4";
            e.rtag = e.vld ? (sel ? "R7 R8" : "R6 R8") : (cut ? "R9" : "R8");
            rx_bit = ins ? rxb[7 - (n - first)] : n[0];
            q.push_back(e);
        end
    endtask

    initial begin
        rst = 1'b1; sync_in = 1'b0; slot_sel = 1'b0; tx_byte = 8'h00; rx_bit = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "tx_oe", int'(tx_oe), 0);
        chk("R1", "rx_valid", int'(rx_valid), 0);
        chk("R1", "rx_byte", int'(rx_byte), 0);
        @(posedge clk);
        #2;
        rst = 1'b0;
        idle(6);
        frame(1'b0, 8'hA5, 8'h3C, 21, 1'b0);
        frame(1'b1, 8'h96, 8'hC3, 21, 1'b0);
        frame(1'b0, 8'h5A, 8'h81, 6, 1'b1);   // R9: restart inside B1
        frame(1'b1, 8'h0F, 8'h6E, 21, 1'b0);
        frame(1'b1, 8'hF0, 8'h99, 14, 1'b1);  // R9: restart inside B2
        frame(1'b0, 8'h01, 8'h80, 21, 1'b0);
        idle(8);
        frame(1'b0, 8'hFF, 8'h00, 21, 1'b0);
        frame(1'b1, 8'h00, 8'hFF, 21, 1'b0);
        idle(4);
        @(posedge clk);
        #8;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule